// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products logic array. It takes the OR of the array's product terms and the array's own output-enable term. From these it drives a pad model: a data value and a drive-enable. It also hands two signals back to the array: the register state, and the level seen at the pin.

A three-bit configuration word picks one of eight modes. The first choice is whether the pad shows the stored register or the live OR result. The second is whether the value is inverted on the way out. The third is whether the pad is enabled by a dedicated external enable input or by the array's enable term.

The D register runs on the shared global clock. A synchronous reset puts it in its power-up state. A test preload path can force it to any value.

Top module: `omc_macrocell`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared to 0 (`fb_q` = 0) after that edge. Reset wins over both preload and capture.
- R2: With `cfg[1]`=1 (registered), the register captures `sum_in` at each rising edge. `pad_out` shows the register value, and a change of `sum_in` between edges does not move `pad_out`.
- R3: With `cfg[0]`=1 (active-low), `pad_out` is the inverse of the selected source. With `cfg[0]`=0 it is the source unchanged.
- R4: With `cfg[1]`=0 (combinational), `pad_out` follows `sum_in` (polarity applied) in the same cycle, with no clock edge needed.
- R5: With `cfg[2]`=1, `pad_oe` equals `ext_oe`. With `cfg[2]`=0, `pad_oe` equals `oe_term`.
- R6: `fb_q` always carries the register value, in both registered and combinational modes. The register keeps capturing `sum_in` in combinational mode.
- R7: `pin_fb` equals `pad_out` while `pad_oe` is 1. It equals the external level `pad_in` while `pad_oe` is 0, so the pin then acts as an input.
- R8: When `preload_en` is high at a rising edge (and `rst` is low), the register takes `preload_val` instead of `sum_in`.
- R9: The erased configuration `cfg`=3'b111 means registered, active-low, enabled by `ext_oe`. Out of reset it gives `pad_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared global clock |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| cfg | input | 3 | Mode: [2] external enable, [1] registered, [0] active-low |
| sum_in | input | 1 | OR of the cell's product terms |
| oe_term | input | 1 | Array-generated enable term |
| ext_oe | input | 1 | Dedicated external enable pin |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value forced into the register on preload |
| pad_in | input | 1 | Level present at the pin from outside |
| pad_out | output | 1 | Value driven toward the pin |
| pad_oe | output | 1 | Drive enable for the pin |
| fb_q | output | 1 | Register state returned to the array |
| pin_fb | output | 1 | Pin level returned to the array |

## Verification
A preload strobe and a normal capture of `sum_in` can fall on the same clock edge, and reset can land on top of both. The bench drives `preload_en` together with a `sum_in` of the opposite value, in both directions. It then judges which one the register took by reading `fb_q` and `pad_out` after the edge. A final step raises reset with preload and `sum_in` both at 1 and expects the register to read 0.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef struct packed {
    logic ext_en;     // 1: enable from ext_oe, 0: from oe_term
    logic registered; // 1: pad shows register, 0: shows sum_in
    logic active_low; // 1: invert on the way out
  } omc_cfg_t;

  localparam int CFG_W = $bits(omc_cfg_t);
  localparam omc_cfg_t OMC_ERASED = '{ext_en: 1'b1, registered: 1'b1, active_low: 1'b1};
endpackage

// File: rtl/omc_dreg.sv
module omc_dreg #(
  parameter logic INIT_Q = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic pl_en,
  input  logic pl_val,
  output logic q
);
  // reset > preload > capture
  always_ff @(posedge clk) begin
    if (rst)        q <= INIT_Q;
    else if (pl_en) q <= pl_val;
    else            q <= d;
  end

  p_reset_init_r1: assert property (@(posedge clk) rst |=> q == INIT_Q)
    else $error("register not at init after reset");
  p_preload_wins_r8: assert property (@(posedge clk) disable iff (rst)
    pl_en |=> q == $past(pl_val))
    else $error("preload value not taken");
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !pl_en |=> q == $past(d))
    else $error("capture of d missed");
endmodule

// File: rtl/omc_polsel.sv
module omc_polsel (
  input  logic use_reg,
  input  logic invert,
  input  logic q,
  input  logic sum,
  output logic y
);
  logic src;
  always_comb begin
    src = use_reg ? q : sum;
    y   = invert ? ~src : src;
  end
endmodule

// File: rtl/omc_oesel.sv
module omc_oesel (
  input  logic ext_sel,
  input  logic ext_oe,
  input  logic oe_term,
  output logic oe
);
  always_comb oe = ext_sel ? ext_oe : oe_term;
endmodule

// File: rtl/omc_macrocell.sv
module omc_macrocell
  import omc_pkg::*;
#(
  parameter logic INIT_Q = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_in,
  input  logic             oe_term,
  input  logic             ext_oe,
  input  logic             preload_en,
  input  logic             preload_val,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb_q,
  output logic             pin_fb
);
  omc_cfg_t mode;
  logic     q;

  assign mode = omc_cfg_t'(cfg);

  omc_dreg #(.INIT_Q(INIT_Q)) u_reg (
    .clk(clk), .rst(rst), .d(sum_in),
    .pl_en(preload_en), .pl_val(preload_val), .q(q)
  );

  omc_polsel u_pol (
    .use_reg(mode.registered), .invert(mode.active_low),
    .q(q), .sum(sum_in), .y(pad_out)
  );

  omc_oesel u_oe (
    .ext_sel(mode.ext_en), .ext_oe(ext_oe), .oe_term(oe_term), .oe(pad_oe)
  );

  assign fb_q   = q;
  assign pin_fb = pad_oe ? pad_out : pad_in;

  p_reg_out_r2: assert property (@(posedge clk) disable iff (rst)
    mode.registered |-> pad_out == (fb_q ^ mode.active_low))
    else $error("registered pad value differs from register");
  p_comb_out_r4: assert property (@(posedge clk) disable iff (rst)
    !mode.registered |-> pad_out == (sum_in ^ mode.active_low))
    else $error("combinational pad value differs from sum");
  p_oe_source_r5: assert property (@(posedge clk) disable iff (rst)
    pad_oe == (mode.ext_en ? ext_oe : oe_term))
    else $error("enable source wrong");
  p_input_pin_r7: assert property (@(posedge clk) disable iff (rst)
    !pad_oe |-> pin_fb == pad_in)
    else $error("disabled pin does not read external level");
endmodule

// File: tb/sim_omc_macrocell.sv
module sim_omc_macrocell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg = 3'b111;
  logic       sum_in = 0, oe_term = 0, ext_oe = 0;
  logic       preload_en = 0, preload_val = 0, pad_in = 0;
  logic       pad_out, pad_oe, fb_q, pin_fb;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk; // 50 MHz

  omc_macrocell u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .sum_in(sum_in), .oe_term(oe_term),
    .ext_oe(ext_oe), .preload_en(preload_en), .preload_val(preload_val),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_q(fb_q),
    .pin_fb(pin_fb)
  );

  // {cfg[2:0], sum, oe_term, ext_oe, preload_en, preload_val, pad_in, exp_q}
  localparam logic [9:0] VEC [0:9] = '{
    10'b111_1_0_1_0_0_0_1, // registered, active-low, external enable
    10'b110_0_0_0_0_0_1_0, // registered, active-high, disabled -> input
    10'b101_1_0_1_0_0_0_1, // combinational, active-low, external
    10'b100_0_0_1_0_0_0_0, // combinational, active-high, external
    10'b011_1_1_0_0_0_0_1, // registered, active-low, term enable
    10'b010_0_0_0_0_0_0_0, // registered, active-high, term disabled
    10'b001_0_1_0_0_0_0_0, // combinational, active-low, term
    10'b000_1_1_0_0_0_0_1, // combinational, active-high, term
    10'b110_0_0_1_1_1_0_1, // preload 1 against sum 0
    10'b110_1_0_1_1_0_0_0  // preload 0 against sum 1
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic eq, eo, eoe, epin;
    repeat (2) @(posedge clk);
    #5;
    // R1 / R9: reset state in the erased mode
    chk("R1 reset fb_q", fb_q, 1'b0);
    chk("R9 erased pad_out", pad_out, 1'b1);
    chk("R9 erased pad_oe from ext_oe", pad_oe, ext_oe);
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {cfg, sum_in, oe_term, ext_oe, preload_en, preload_val, pad_in, eq} = VEC[i];
      @(posedge clk);
      #5;
      eo   = (cfg[1] ? eq : sum_in) ^ cfg[0];
      eoe  = cfg[2] ? ext_oe : oe_term;
      epin = eoe ? eo : pad_in;
      chk($sformatf("R6 R8 R2 fb_q vec%0d", i), fb_q, eq);
      chk($sformatf("R3 R4 pad_out vec%0d", i), pad_out, eo);
      chk($sformatf("R5 pad_oe vec%0d", i), pad_oe, eoe);
      chk($sformatf("R7 pin_fb vec%0d", i), pin_fb, epin);
    end

    // R2: registered output ignores sum_in until the next edge (q is 0 now)
    @(negedge clk);
    preload_en = 0; cfg = 3'b110; sum_in = 1;
    #2 chk("R2 no change before edge", pad_out, 1'b0);
    @(posedge clk);
    #5 chk("R2 captured after edge", pad_out, 1'b1);

    // R4 / R6: combinational output moves within the cycle; register holds
    @(negedge clk);
    cfg = 3'b100; sum_in = 0;
    #1 chk("R4 comb follows 0", pad_out, 1'b0);
    chk("R6 fb_q holds before edge", fb_q, 1'b1);
    sum_in = 1;
    #1 chk("R4 comb follows 1", pad_out, 1'b1);
    @(negedge clk);
    sum_in = 0;
    @(posedge clk);
    #5 chk("R6 register captures in comb mode", fb_q, 1'b0);

    // R1: reset beats preload and capture
    @(negedge clk);
    sum_in = 1; preload_en = 1; preload_val = 1;
    @(posedge clk);
    #5 chk("R8 setup fb_q", fb_q, 1'b1);
    @(negedge clk);
    rst = 1; cfg = 3'b111;
    @(posedge clk);
    #5 chk("R1 reset over preload", fb_q, 1'b0);
    chk("R9 erased pad_out after reset", pad_out, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule